// File: doc/BRIEF.md
# PS/2 Device-Side Link Controller

This block is the peripheral end of a PS/2 link, the side a keyboard or pointing device would hold. It owns the link clock. It sends a programmed run of bytes to the host from a small transmit store. When the host asks to talk, it clocks in the host's byte, checks its framing and keeps the result in a two-entry receive store. The pads are open-drain: each line has a "pull low" enable output and a synchronised input, and the bench or the pad ring forms the wired-AND.

Firmware fills the transmit store one byte per write strobe. It then gives a length code and a go strobe, and it collects received bytes by popping the receive store. A monitor watches the clock line. It reports a host inhibit when the host holds the clock low long enough, and it reports a request-to-send when the host lets the clock go while holding data low. If the host seizes the clock during a device transmission, the current byte is dropped from the wire, kept in the store, and sent again from its start bit once the bus is idle. An override input hands both lines straight to two control bits and freezes the protocol engine.

Top module: `ps2_dev_top`

## Requirements
- R1: Every device-sent frame is 11 bits: start 0, eight data bits least significant first, an odd parity bit (data plus parity hold an odd number of ones), stop 1. Data changes only while the clock is released, so the host samples it on the clock's falling edge.
- R2: Every low phase of the clock that the device drives lasts exactly HALF_CYC system cycles. The default, 4000 cycles at 100 MHz, gives 12.5 kHz.
- R3: After a go strobe with length code L (0 to 15), the first L+1 stored bytes are sent in write order. tx_busy stays high until then, and tx_done pulses for one cycle after the last stop bit. The write position returns to slot 0 after each run.
- R4: host_inhibit rises once the clock line has been low, and not driven by the device, for INHIBIT_CYC cycles. The default is 10000 cycles, or 100 us. It falls within a few cycles of the host releasing the clock.
- R5: When the host releases the clock after an inhibit while data is low, host_rts pulses for one cycle and the device starts clocking in a host frame. If data is high at the release, there is no pulse.
- R6: A host frame is assembled least significant bit first. On a well-formed frame the device pulls data low through one extra clock pulse after the stop bit (the acknowledge).
- R7: A frame whose start bit is 1, whose stop bit is 0 or whose parity is even is still stored, with rx_err set, and is not acknowledged.
- R8: The receive store holds two frames in arrival order. rx_pop removes the oldest, and a frame that arrives while both entries are full is discarded.
- R9: If the clock reads low at the end of a device high phase during a transmission, the device releases both lines and keeps the byte. It then resends the whole byte once the bus is idle, after any host frame the host asks to send.
- R10: While sw_ovr is high, ps2_clk_oe equals sw_clk_low and ps2_dat_oe equals sw_dat_low on every cycle. The engine abandons any frame in flight, and a pending transmit byte is kept and sent in full after the override ends.
- R11: After reset both line drivers are off, tx_busy, rx_valid, host_inhibit and host_rts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Clock line as seen at the pad |
| ps2_dat_i | input | 1 | Data line as seen at the pad |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| tx_len | input | 4 | Run length code, bytes sent = tx_len+1 |
| tx_wr | input | 1 | Store tx_wdata in the next slot (ignored while busy) |
| tx_wdata | input | 8 | Byte to store |
| tx_go | input | 1 | Start sending the stored run |
| tx_busy | output | 1 | A run is in progress |
| tx_done | output | 1 | One-cycle pulse when a run ends |
| rx_valid | output | 1 | Receive store holds at least one frame |
| rx_data | output | 8 | Oldest received byte |
| rx_err | output | 1 | Oldest received frame was malformed |
| rx_pop | input | 1 | Drop the oldest received frame |
| host_inhibit | output | 1 | Host is holding the clock low |
| host_rts | output | 1 | One-cycle pulse on a host request-to-send |
| sw_ovr | input | 1 | Hand both lines to the control bits |
| sw_clk_low | input | 1 | Override value for the clock driver |
| sw_dat_low | input | 1 | Override value for the data driver |

## Verification
A wrong engine state shows first on the line drivers. A misplaced shift or bit count corrupts the parity or stop bit of the very frame it happens in. A wrong timer changes the length of the next clock low phase. A receive state that does not advance on time moves or loses the acknowledge pulse one or two clock periods after the stop bit. Faults in the stores show later and only at the software side: a wrong pointer sends bytes out of order or too many, which the host model sees within one run, and a wrong receive fill state shows as a lost or duplicated byte at the next pops. The abort path stays hidden until the host seizes the clock, and then shows as a missing or truncated resend.

// File: rtl/ps2_dev_pkg.sv
package ps2_dev_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_H,
    ST_TX_L,
    ST_RX_H,
    ST_RX_L,
    ST_ACK_H,
    ST_ACK_L,
    ST_GAP
  } eng_state_t;

  typedef struct packed {
    logic       err;
    logic [7:0] data;
  } rx_entry_t;

  // Bit that makes data plus parity hold an odd count of ones
  function automatic logic odd_par(input logic [7:0] d);
    return ~^d;
  endfunction

endpackage

// File: rtl/ps2_dev_linemon.sv
module ps2_dev_linemon #(
  parameter int INHIBIT_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_pad_i,
  input  logic dat_pad_i,
  input  logic own_clk_low,
  output logic clk_s,
  output logic dat_s,
  output logic inhibit,
  output logic rts_pulse
);

  localparam int CW = $clog2(INHIBIT_CYC + 1);

  logic         clk_m_q, dat_m_q, clk_s_q, dat_s_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic         inh_q, inh_n, rts_q, rts_n;

  always_comb begin
    if (!clk_s_q && !own_clk_low) begin
      cnt_n = (cnt_q == CW'(INHIBIT_CYC)) ? cnt_q : cnt_q + 1'b1;
    end else begin
      cnt_n = '0;
    end
    inh_n = (cnt_n == CW'(INHIBIT_CYC));
    rts_n = inh_q && clk_s_q && !dat_s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_m_q <= 1'b1;
      dat_m_q <= 1'b1;
      clk_s_q <= 1'b1;
      dat_s_q <= 1'b1;
      cnt_q   <= '0;
      inh_q   <= 1'b0;
      rts_q   <= 1'b0;
    end else begin
      clk_m_q <= clk_pad_i;
      dat_m_q <= dat_pad_i;
      clk_s_q <= clk_m_q;
      dat_s_q <= dat_m_q;
      cnt_q   <= cnt_n;
      inh_q   <= inh_n;
      rts_q   <= rts_n;
    end
  end

  assign clk_s     = clk_s_q;
  assign dat_s     = dat_s_q;
  assign inhibit   = inh_q;
  assign rts_pulse = rts_q;

  p_inhibit_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inh_q) |-> $past(!clk_s_q));

  p_rts_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rts_q |=> !rts_q);

endmodule

// File: rtl/ps2_dev_txbuf.sv
module ps2_dev_txbuf #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [7:0]               wdata,
  input  logic                     go,
  input  logic [$clog2(DEPTH)-1:0] len,
  input  logic                     byte_sent,
  output logic                     busy,
  output logic                     done,
  output logic [7:0]               cur_byte
);

  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n, len_q, len_n;
  logic          busy_q, busy_n, done_n, done_q;
  logic          mem_we;

  assign mem_we = wr && !busy_q && !go;

  always_comb begin
    wp_n   = wp_q;
    rp_n   = rp_q;
    len_n  = len_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (go) begin
        busy_n = 1'b1;
        len_n  = len;
        rp_n   = '0;
      end else if (wr) begin
        wp_n = wp_q + 1'b1;
      end
    end else if (byte_sent) begin
      if (rp_q == len_q) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        wp_n   = '0;
      end else begin
        rp_n = rp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      len_q  <= len_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (mem_we && wp_q == PW'(i)) begin
        mem_q[i] <= wdata;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cur_byte = mem_q[rp_q];

  p_rd_within_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rp_q <= len_q));

  p_done_ends_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

endmodule

// File: rtl/ps2_dev_rxbuf.sv
module ps2_dev_rxbuf
  import ps2_dev_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t push_ent,
  input  logic      pop,
  output logic      valid,
  output rx_entry_t front
);

  rx_entry_t f_q, f_n, b_q, b_n;
  logic      fv_q, fv_n, bv_q, bv_n;

  always_comb begin
    f_n  = f_q;
    b_n  = b_q;
    fv_n = fv_q;
    bv_n = bv_q;
    if (pop && fv_q) begin
      f_n  = b_q;
      fv_n = bv_q;
      bv_n = 1'b0;
    end
    if (push) begin
      if (!fv_n) begin
        f_n  = push_ent;
        fv_n = 1'b1;
      end else if (!bv_n) begin
        b_n  = push_ent;
        bv_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      bv_q <= 1'b0;
      f_q  <= '0;
      b_q  <= '0;
    end else begin
      fv_q <= fv_n;
      bv_q <= bv_n;
      f_q  <= f_n;
      b_q  <= b_n;
    end
  end

  assign valid = fv_q;
  assign front = f_q;

  p_back_needs_front_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> fv_q);

  p_full_keeps_front_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fv_q && bv_q && !pop) |=> (fv_q && bv_q && $stable(f_q)));

endmodule

// File: rtl/ps2_dev_engine.sv
module ps2_dev_engine
  import ps2_dev_pkg::*;
#(
  parameter int HALF_CYC = 4000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      freeze,
  input  logic      clk_s,
  input  logic      dat_s,
  input  logic      inhibit,
  input  logic      rts_pulse,
  input  logic      tx_req,
  input  logic [7:0] tx_byte,
  output logic      drv_clk,
  output logic      drv_dat,
  output logic      byte_sent,
  output logic      rx_push,
  output rx_entry_t rx_ent
);

  localparam int TW = $clog2(HALF_CYC);
  localparam logic [3:0] LAST_BIT = 4'd10;

  eng_state_t   st_q, st_n;
  logic [TW-1:0] t_q, t_n;
  logic [3:0]   bit_q, bit_n;
  logic [10:0]  sh_q, sh_n;
  logic         pend_q, pend_n;
  logic         end_ph, good, bus_idle;

  assign end_ph   = (t_q == TW'(HALF_CYC - 1));
  assign bus_idle = clk_s && dat_s;
  assign good     = !sh_q[0] && sh_q[10] && (^sh_q[9:1]);

  always_comb begin
    st_n      = st_q;
    t_n       = end_ph ? '0 : t_q + 1'b1;
    bit_n     = bit_q;
    sh_n      = sh_q;
    pend_n    = pend_q || rts_pulse;
    byte_sent = 1'b0;
    rx_push   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!bus_idle)   t_n = '0;
        else if (end_ph) t_n = t_q;
        if (pend_q) begin
          st_n   = ST_RX_H;
          t_n    = '0;
          bit_n  = '0;
          pend_n = 1'b0;
        end else if (tx_req && !inhibit && bus_idle && end_ph) begin
          st_n  = ST_TX_H;
          t_n   = '0;
          bit_n = '0;
          sh_n  = {1'b1, odd_par(tx_byte), tx_byte, 1'b0};
        end
      end
      ST_TX_H: if (end_ph) st_n = clk_s ? ST_TX_L : ST_IDLE;
      ST_TX_L: begin
        if (end_ph) begin
          if (bit_q == LAST_BIT) begin
            st_n      = ST_GAP;
            byte_sent = 1'b1;
          end else begin
            sh_n  = {1'b1, sh_q[10:1]};
            bit_n = bit_q + 1'b1;
            st_n  = ST_TX_H;
          end
        end
      end
      ST_RX_H: begin
        if (end_ph) begin
          if (!clk_s) begin
            st_n = ST_IDLE;
          end else begin
            sh_n = {dat_s, sh_q[10:1]};
            st_n = ST_RX_L;
          end
        end
      end
      ST_RX_L: begin
        if (end_ph) begin
          if (bit_q == LAST_BIT) begin
            rx_push = 1'b1;
            st_n    = good ? ST_ACK_H : ST_GAP;
          end else begin
            bit_n = bit_q + 1'b1;
            st_n  = ST_RX_H;
          end
        end
      end
      ST_ACK_H: if (end_ph) st_n = ST_ACK_L;
      ST_ACK_L: if (end_ph) st_n = ST_GAP;
      ST_GAP:   if (end_ph) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
    if (freeze) begin
      st_n   = ST_IDLE;
      t_n    = '0;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      t_q    <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      t_q    <= t_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      pend_q <= pend_n;
    end
  end

  assign drv_clk = (st_q == ST_TX_L) || (st_q == ST_RX_L) || (st_q == ST_ACK_L);
  assign drv_dat = ((st_q == ST_TX_H) || (st_q == ST_TX_L)) ? !sh_q[0]
                 : ((st_q == ST_ACK_H) || (st_q == ST_ACK_L));
  assign rx_ent.err  = !good;
  assign rx_ent.data = sh_q[8:1];

  p_data_still_in_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_L && $past(st_q) == ST_TX_L) |-> $stable(drv_dat));

  p_timer_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    t_q <= TW'(HALF_CYC - 1));

  p_push_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  p_abort_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_H && end_ph && !clk_s && !freeze) |=> (!drv_clk && !drv_dat));

endmodule

// File: rtl/ps2_dev_top.sv
module ps2_dev_top
  import ps2_dev_pkg::*;
#(
  parameter int HALF_CYC    = 4000,
  parameter int INHIBIT_CYC = 10000,
  parameter int TX_DEPTH    = 16,
  localparam int LW         = $clog2(TX_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ps2_clk_i,
  input  logic          ps2_dat_i,
  output logic          ps2_clk_oe,
  output logic          ps2_dat_oe,
  input  logic [LW-1:0] tx_len,
  input  logic          tx_wr,
  input  logic [7:0]    tx_wdata,
  input  logic          tx_go,
  output logic          tx_busy,
  output logic          tx_done,
  output logic          rx_valid,
  output logic [7:0]    rx_data,
  output logic          rx_err,
  input  logic          rx_pop,
  output logic          host_inhibit,
  output logic          host_rts,
  input  logic          sw_ovr,
  input  logic          sw_clk_low,
  input  logic          sw_dat_low
);

  logic      clk_s, dat_s, inh, rts;
  logic      eng_clk, eng_dat, sent, push;
  logic [7:0] cur;
  rx_entry_t ent, head;

  assign ps2_clk_oe = sw_ovr ? sw_clk_low : eng_clk;
  assign ps2_dat_oe = sw_ovr ? sw_dat_low : eng_dat;

  ps2_dev_linemon #(.INHIBIT_CYC(INHIBIT_CYC)) u_mon (
    .clk(clk), .rst_n(rst_n),
    .clk_pad_i(ps2_clk_i), .dat_pad_i(ps2_dat_i), .own_clk_low(ps2_clk_oe),
    .clk_s(clk_s), .dat_s(dat_s), .inhibit(inh), .rts_pulse(rts)
  );

  ps2_dev_txbuf #(.DEPTH(TX_DEPTH)) u_txb (
    .clk(clk), .rst_n(rst_n),
    .wr(tx_wr), .wdata(tx_wdata), .go(tx_go), .len(tx_len),
    .byte_sent(sent), .busy(tx_busy), .done(tx_done), .cur_byte(cur)
  );

  ps2_dev_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .freeze(sw_ovr),
    .clk_s(clk_s), .dat_s(dat_s), .inhibit(inh), .rts_pulse(rts),
    .tx_req(tx_busy), .tx_byte(cur),
    .drv_clk(eng_clk), .drv_dat(eng_dat), .byte_sent(sent),
    .rx_push(push), .rx_ent(ent)
  );

  ps2_dev_rxbuf u_rxb (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_ent(ent), .pop(rx_pop),
    .valid(rx_valid), .front(head)
  );

  assign rx_data      = head.data;
  assign rx_err       = head.err;
  assign host_inhibit = inh;
  assign host_rts     = rts;

  p_override_freezes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ovr |=> (!eng_clk && !eng_dat));

  p_sent_only_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sent |-> tx_busy);

endmodule

// File: tb/tb_ps2_dev_top.sv
module tb_ps2_dev_top;

  localparam int HALF = 8;
  localparam int INH  = 40;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic       host_clk_low, host_dat_low;
  logic       clk_oe, dat_oe;
  logic [3:0] tx_len;
  logic       tx_wr, tx_go, rx_pop, sw_ovr, sw_clk_low, sw_dat_low;
  logic [7:0] tx_wdata, rx_data;
  logic       tx_busy, tx_done, rx_valid, rx_err, host_inhibit, host_rts;
  wire        clk_pad = ~(clk_oe | host_clk_low);
  wire        dat_pad = ~(dat_oe | host_dat_low);

  ps2_dev_top #(.HALF_CYC(HALF), .INHIBIT_CYC(INH), .TX_DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .ps2_clk_i(clk_pad), .ps2_dat_i(dat_pad),
    .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe),
    .tx_len(tx_len), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_go(tx_go),
    .tx_busy(tx_busy), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_pop(rx_pop),
    .host_inhibit(host_inhibit), .host_rts(host_rts),
    .sw_ovr(sw_ovr), .sw_clk_low(sw_clk_low), .sw_dat_low(sw_dat_low)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  int  rts_seen = 0;
  bit  hmode = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Per-clock reference: host-side frame decoding, phase timing, override mirror
  bit   prev_pad = 1, prev_oe = 0, prev_ovr = 0;
  int   nbits = 0, quiet = 0, low_len = 0;
  logic [10:0] fr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_rts) rts_seen++;
      if (sw_ovr) begin
        chk(clk_oe == sw_clk_low && dat_oe == sw_dat_low, "R10 pad mirror",
            {clk_oe, dat_oe}, {sw_clk_low, sw_dat_low});
      end
      if (clk_oe) low_len++;
      else begin
        if (prev_oe && !sw_ovr && !prev_ovr)
          chk(low_len == HALF, "R2 low phase", low_len, HALF);
        low_len = 0;
      end
      if (hmode || sw_ovr) begin
        nbits = 0;
      end else if (prev_pad && !clk_pad) begin
        fr[nbits] = dat_pad;
        nbits++;
        quiet = 0;
        if (nbits == 11) begin
          nbits = 0;
          chk(!fr[0] && fr[10] && (^fr[9:1]), "R1 frame bits", fr, 0);
          got_q.push_back(fr[8:1]);
        end
      end else begin
        quiet++;
        if (quiet > 4 * HALF) nbits = 0;
      end
      prev_pad = clk_pad;
      prev_oe  = clk_oe;
      prev_ovr = sw_ovr;
    end
  end

  task automatic wait_fall(output bit seen, input int tmo);
    bit p;
    seen = 0;
    p = clk_pad;
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (p && !clk_pad) begin
        seen = 1;
        return;
      end
      p = clk_pad;
    end
  endtask

  task automatic load_run(input logic [7:0] b[$]);
    foreach (b[i]) begin
      @(negedge clk); tx_wr = 1; tx_wdata = b[i];
      exp_q.push_back(b[i]);
    end
    @(negedge clk); tx_wr = 0; tx_len = 4'(b.size() - 1); tx_go = 1;
    @(negedge clk); tx_go = 0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 8000 && !seen; i++) begin
      @(negedge clk);
      if (tx_done) seen = 1;
    end
    chk(seen, req, seen, 1);
    repeat (4 * HALF) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      logic [7:0] e, g;
      e = exp_q.pop_front(); g = got_q.pop_front();
      chk(e == g, req, g, e);
    end
    exp_q.delete(); got_q.delete();
  endtask

  task automatic host_send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                           output bit acked);
    logic [9:0] bits;
    bit seen;
    bits = {~bad_stop, (~^d) ^ bad_par, d};
    hmode = 1; acked = 0;
    host_clk_low = 1;
    repeat (INH + 30) @(negedge clk);
    host_dat_low = 1;
    repeat (5) @(negedge clk);
    host_clk_low = 0;
    for (int k = 0; k < 10; k++) begin
      wait_fall(seen, 6 * HALF);
      host_dat_low = ~bits[k];
    end
    wait_fall(seen, 6 * HALF);
    host_dat_low = 0;
    wait_fall(seen, 6 * HALF);
    acked = seen && !dat_pad;
    repeat (2 * HALF) @(negedge clk);
    hmode = 0;
  endtask

  task automatic pop_chk(input logic [7:0] d, input bit e, input string req);
    @(negedge clk);
    chk(rx_valid && rx_data == d && rx_err == e, req, {rx_valid, rx_err, rx_data}, {1'b1, e, d});
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] run[$];
    bit ack, seen;
    int r0;
    rst_n = 0; host_clk_low = 0; host_dat_low = 0;
    tx_len = 0; tx_wr = 0; tx_go = 0; tx_wdata = 0; rx_pop = 0;
    sw_ovr = 0; sw_clk_low = 0; sw_dat_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!clk_oe && !dat_oe && !tx_busy && !rx_valid && !host_inhibit && !host_rts,
        "R11 reset", {clk_oe, dat_oe, tx_busy, rx_valid, host_inhibit, host_rts}, 0);

    // R1 R3 three-byte run with mixed patterns
    run = '{8'hA5, 8'h3C, 8'h00};
    load_run(run);
    chk(tx_busy, "R3 busy after go", tx_busy, 1);
    wait_done("R3 three-byte run");

    // R3 minimum length
    run = '{8'hFF};
    load_run(run);
    wait_done("R3 single byte");

    // R3 maximum length, 16 bytes
    run.delete();
    for (int i = 0; i < 16; i++) run.push_back(8'(i * 37 + 1));
    load_run(run);
    wait_done("R3 sixteen bytes");

    // R4 inhibit timing, R5 no request when data high at release
    r0 = rts_seen;
    host_clk_low = 1;
    repeat (INH - 5) @(negedge clk);
    chk(!host_inhibit, "R4 not yet inhibited", host_inhibit, 0);
    repeat (15) @(negedge clk);
    chk(host_inhibit, "R4 inhibited", host_inhibit, 1);
    host_clk_low = 0;
    repeat (6) @(negedge clk);
    chk(!host_inhibit, "R4 release clears", host_inhibit, 0);
    repeat (4 * HALF) @(negedge clk);
    chk(rts_seen == r0 && !clk_oe, "R5 no request", rts_seen - r0, 0);

    // R5 R6 good host frame
    r0 = rts_seen;
    host_send(8'h5A, 0, 0, ack);
    chk(rts_seen == r0 + 1, "R5 request pulse", rts_seen - r0, 1);
    chk(ack, "R6 acknowledge", ack, 1);
    // R7 bad parity, R8 second entry, third frame dropped
    host_send(8'h33, 1, 0, ack);
    chk(!ack, "R7 no ack on parity error", ack, 0);
    host_send(8'h81, 0, 0, ack);
    pop_chk(8'h5A, 0, "R6 R8 oldest entry");
    pop_chk(8'h33, 1, "R7 R8 second entry");
    @(negedge clk);
    chk(!rx_valid, "R8 third dropped", rx_valid, 0);

    // R7 bad stop bit
    host_send(8'h6E, 0, 1, ack);
    chk(!ack, "R7 no ack on stop error", ack, 0);
    pop_chk(8'h6E, 1, "R7 stop error flagged");

    // R9 abort mid-byte, host frame in between, full resend
    run = '{8'hC3, 8'h96};
    load_run(run);
    for (int i = 0; i < 4; i++) wait_fall(seen, 8 * HALF);
    host_send(8'h42, 0, 0, ack);
    chk(ack, "R9 host frame during abort", ack, 1);
    chk(tx_busy, "R9 run kept", tx_busy, 1);
    wait_done("R9 resend after abort");
    pop_chk(8'h42, 0, "R9 host byte stored");

    // R10 override during a transmission
    run = '{8'hE7};
    load_run(run);
    for (int i = 0; i < 3; i++) wait_fall(seen, 8 * HALF);
    sw_ovr = 1;
    repeat (40) @(negedge clk);
    sw_clk_low = 1;
    repeat (40) @(negedge clk);
    chk(!clk_pad, "R10 clock pulled", clk_pad, 0);
    sw_clk_low = 0; sw_dat_low = 1;
    repeat (40) @(negedge clk);
    chk(!dat_pad && tx_busy, "R10 data pulled, byte kept", {dat_pad, tx_busy}, 1);
    sw_dat_low = 0;
    sw_ovr = 0;
    wait_done("R10 resend after override");

    finish_run();
  end

endmodule